// File: doc/BRIEF.md
# Binary Crossbar Spiking Core

This block is a self-contained spiking core. Input axons reach output neurons through an on/off crossbar, one bit per axon/neuron pair. Incoming spike events carry an axon index and a delay. Each event is parked in a circular schedule of time slots until its tick arrives. On every accepted tick the core reads and clears the slot that is due. It then walks the active axons one per cycle. For each set crosspoint, every neuron adds the signed weight it keeps for that axon's type.

After integration, each neuron adds its signed leak and compares the result with its threshold. A neuron that reaches its threshold fires and restarts from zero. Firing neurons are scanned in ascending index order. Each one either emits an output packet (core offset, target axon, delay) or, when its core offset is zero, writes its spike straight back into the core's own schedule.

Configuration is written through one write port, selected by a kind code. A tick takes N_AXON + N_NEUR + 2 cycles to process. Ticks that arrive while the core is busy are not accepted, so the tick source must space them further apart than that.

Top module: `nsc_core`

## Requirements
- R1: After reset every threshold holds the largest positive potential (2047) and all weights, leaks, crosspoints, types, targets and potentials are zero, so ticks before any configuration produce no packet and out_valid stays low.
- R2: A crosspoint is written with cfg_kind 0, cfg_addr = axon and cfg_data bit n = neuron n. An event on axon a reaches neuron n only when bit n of row a is set.
- R3: An axon type is written with cfg_kind 1 in cfg_data[1:0]. Weights are written with cfg_kind 2: weight t is the signed 9-bit field cfg_data[9t+8:9t]. An active axon of type t adds weight t of each connected neuron.
- R4: An event with delay d is integrated on the (d+1)-th accepted tick after the cycle it arrives in. A tick in the same cycle as the event does not count.
- R5: Threshold (signed 12-bit, cfg_data[11:0]) and leak (signed 9-bit, cfg_data[20:12]) are written with cfg_kind 3. Once per tick, after integration, the leak is added. If the result is at or above the threshold the neuron fires and its potential becomes zero; otherwise the result is kept.
- R6: The potential saturates at +2047 and -2048 on every addition instead of wrapping.
- R7: A target is written with cfg_kind 4: offset in cfg_data[3:0], axon in cfg_data[11:4], delay in cfg_data[15:12]. Each firing neuron with a nonzero offset produces exactly one one-cycle packet carrying its target fields, and packets of one tick leave in ascending neuron order.
- R8: A firing neuron with a zero offset produces no packet. Its spike is scheduled in the core's own schedule on axon (target axon mod N_AXON) with the target delay, using the R4 rule counted from the tick it fired on.
- R9: An external event and a loopback spike written in the same cycle are both kept, even when they target the same slot. An event with delay 15 that arrives together with a tick is delivered 16 ticks later and is not lost to the slot clear.
- R10: Several active axons in one tick add all their contributions to a neuron before the leak and threshold step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-step advance request, accepted only when idle |
| in_valid | input | 1 | External spike event strobe |
| in_axon | input | $clog2(N_AXON) | Axon addressed by the event |
| in_delay | input | 4 | Delay of the event in ticks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | 0 row, 1 type, 2 weights, 3 threshold/leak, 4 target |
| cfg_addr | input | max of axon and neuron index widths | Axon or neuron addressed |
| cfg_data | input | 36 | Configuration payload |
| out_valid | output | 1 | Output packet strobe |
| out_core | output | 4 | Target core offset (never zero) |
| out_axon | output | 8 | Target axon index |
| out_delay | output | 4 | Target axonal delay |

## Verification
Two functions can write the same schedule slot in one cycle: an external event arriving during the emit scan, and a neuron's loopback spike written back at that same scan step. The bench drives the event on the exact cycle the loopback neuron is scanned, aiming both at the same future slot on different axons. It judges the result by both downstream neurons firing on the predicted tick. A second collision, between an event and the slot clear, is provoked by raising a delay-15 event together with the tick. The event must reappear after sixteen ticks. Every tick is compared against a bench-side arithmetic model for packet count, order and fields.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    localparam int W_WT   = 9;
    localparam int W_POT  = 12;
    localparam int W_OFS  = 4;
    localparam int W_TAX  = 8;
    localparam int W_DLY  = 4;
    localparam int W_TYPE = 2;
    localparam int N_TYPE = 1 << W_TYPE;
    localparam int N_SLOT = 1 << W_DLY;
    localparam int W_CFG  = N_TYPE * W_WT;

    localparam logic signed [W_POT-1:0] POT_MAX = {1'b0, {(W_POT-1){1'b1}}};
    localparam logic signed [W_POT-1:0] POT_MIN = {1'b1, {(W_POT-1){1'b0}}};

    typedef enum logic [1:0] {ST_IDLE, ST_INTEG, ST_LEAK, ST_EMIT} phase_e;

    typedef enum logic [2:0] {
        CF_ROW  = 3'd0,
        CF_TYPE = 3'd1,
        CF_WT   = 3'd2,
        CF_THR  = 3'd3,
        CF_TGT  = 3'd4
    } cfg_e;

    // ofs occupies the low bits, then axon, then delay
    typedef struct packed {
        logic [W_DLY-1:0] dly;
        logic [W_TAX-1:0] axon;
        logic [W_OFS-1:0] ofs;
    } tgt_t;

    function automatic logic signed [W_POT-1:0] sext_wt(input logic [W_WT-1:0] w);
        return {{(W_POT-W_WT){w[W_WT-1]}}, w};
    endfunction

    function automatic logic signed [W_POT-1:0] sat_add(input logic signed [W_POT-1:0] a,
                                                        input logic signed [W_POT-1:0] b);
        logic [W_POT:0] s;
        s = {a[W_POT-1], a} + {b[W_POT-1], b};
        if (s[W_POT] != s[W_POT-1])
            return s[W_POT] ? POT_MIN : POT_MAX;
        return s[W_POT-1:0];
    endfunction

endpackage

// File: rtl/nsc_ring.sv
module nsc_ring
    import nsc_pkg::*;
#(
    parameter int N_AXON = 16,
    localparam int AIW = $clog2(N_AXON)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_acc,
    input  logic              ext_we,
    input  logic [AIW-1:0]    ext_axon,
    input  logic [W_DLY-1:0]  ext_dly,
    input  logic              lb_we,
    input  logic [AIW-1:0]    lb_axon,
    input  logic [W_DLY-1:0]  lb_dly,
    output logic [N_AXON-1:0] cur_row
);
    logic [N_AXON-1:0] slots [N_SLOT];
    logic [W_DLY-1:0]  ptr;
    logic [W_DLY-1:0]  base, ext_idx, lb_idx;
    logic [N_AXON-1:0] ext_bit, lb_bit;

    // an event arriving with the tick is placed relative to the advanced pointer
    assign base    = tick_acc ? W_DLY'(ptr + 1'b1) : ptr;
    assign ext_idx = W_DLY'(base + ext_dly);
    assign lb_idx  = W_DLY'(ptr + lb_dly);
    assign ext_bit = {{(N_AXON-1){1'b0}}, 1'b1} << ext_axon;
    assign lb_bit  = {{(N_AXON-1){1'b0}}, 1'b1} << lb_axon;
    assign cur_row = slots[ptr];

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (tick_acc) ptr <= W_DLY'(ptr + 1'b1);
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic [N_AXON-1:0] wmask;
        always_comb begin
            wmask = '0;
            if (ext_we && ext_idx == W_DLY'(s)) wmask = wmask | ext_bit;
            if (lb_we && lb_idx == W_DLY'(s))   wmask = wmask | lb_bit;
        end
        always_ff @(posedge clk) begin
            if (rst) slots[s] <= '0;
            else slots[s] <= ((tick_acc && ptr == W_DLY'(s)) ? '0 : slots[s]) | wmask;
        end
    end

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        tick_acc |=> ptr == W_DLY'($past(ptr) + 1'b1));

    p_slot_cleared_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_acc && !ext_we && !lb_we) |=> slots[$past(ptr)] == '0);

endmodule

// File: rtl/nsc_xbar.sv
module nsc_xbar
    import nsc_pkg::*;
#(
    parameter int N_AXON = 16,
    parameter int N_NEUR = 16,
    localparam int AIW = $clog2(N_AXON)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_row,
    input  logic              we_type,
    input  logic [AIW-1:0]    addr,
    input  logic [N_NEUR-1:0] row_data,
    input  logic [W_TYPE-1:0] type_data,
    input  logic [AIW-1:0]    rd_idx,
    output logic [N_NEUR-1:0] rd_row,
    output logic [W_TYPE-1:0] rd_type
);
    logic [N_NEUR-1:0] rows  [N_AXON];
    logic [W_TYPE-1:0] types [N_AXON];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < N_AXON; a++) begin
                rows[a]  <= '0;
                types[a] <= '0;
            end
        end else begin
            if (we_row)  rows[addr]  <= row_data;
            if (we_type) types[addr] <= type_data;
        end
    end

    assign rd_row  = rows[rd_idx];
    assign rd_type = types[rd_idx];

    p_row_write_r2: assert property (@(posedge clk) disable iff (rst)
        we_row |=> rows[$past(addr)] == $past(row_data));

endmodule

// File: rtl/nsc_neuron.sv
module nsc_neuron
    import nsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_wt,
    input  logic              we_thr,
    input  logic              we_tgt,
    input  logic [W_CFG-1:0]  cfg_data,
    input  logic              integ_en,
    input  logic [W_TYPE-1:0] atype,
    input  logic              leak_en,
    output logic              fired,
    output tgt_t              tgt
);
    logic [W_WT-1:0]         wt [N_TYPE];
    logic signed [W_POT-1:0] thr, pot, wext, after_leak;
    logic [W_WT-1:0]         leak;

    assign wext       = sext_wt(wt[atype]);
    assign after_leak = sat_add(pot, sext_wt(leak));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < N_TYPE; t++) wt[t] <= '0;
            thr   <= POT_MAX;
            leak  <= '0;
            tgt   <= '0;
            pot   <= '0;
            fired <= 1'b0;
        end else begin
            if (we_wt)
                for (int t = 0; t < N_TYPE; t++) wt[t] <= cfg_data[t*W_WT +: W_WT];
            if (we_thr) begin
                thr  <= cfg_data[W_POT-1:0];
                leak <= cfg_data[W_POT +: W_WT];
            end
            if (we_tgt) tgt <= cfg_data[$bits(tgt_t)-1:0];
            if (integ_en) begin
                pot <= sat_add(pot, wext);
            end else if (leak_en) begin
                if (after_leak >= thr) begin
                    pot   <= '0;
                    fired <= 1'b1;
                end else begin
                    pot   <= after_leak;
                    fired <= 1'b0;
                end
            end
        end
    end

    p_fire_zero_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(leak_en) && fired) |-> pot == '0);

    p_sat_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(integ_en) && $past(pot) == POT_MAX && !$past(wext[W_POT-1])) |-> pot == POT_MAX);

    p_sat_floor_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(integ_en) && $past(pot) == POT_MIN && $past(wext[W_POT-1])) |-> pot == POT_MIN);

endmodule

// File: rtl/nsc_core.sv
module nsc_core
    import nsc_pkg::*;
#(
    parameter int N_AXON = 16,
    parameter int N_NEUR = 16,
    localparam int AIW = $clog2(N_AXON),
    localparam int NIW = $clog2(N_NEUR),
    localparam int CAW = (AIW > NIW) ? AIW : NIW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              in_valid,
    input  logic [AIW-1:0]    in_axon,
    input  logic [W_DLY-1:0]  in_delay,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_kind,
    input  logic [CAW-1:0]    cfg_addr,
    input  logic [W_CFG-1:0]  cfg_data,
    output logic              out_valid,
    output logic [W_OFS-1:0]  out_core,
    output logic [W_TAX-1:0]  out_axon,
    output logic [W_DLY-1:0]  out_delay
);
    phase_e            state;
    logic [AIW-1:0]    aidx;
    logic [NIW-1:0]    nidx;
    logic [N_AXON-1:0] act_q, due_row;
    logic [N_NEUR-1:0] xb_row, fired;
    logic [W_TYPE-1:0] xb_type;
    tgt_t              tgts [N_NEUR];
    tgt_t              sel;
    logic              tick_acc, sel_fire, lb_we, ext_pkt;

    assign tick_acc = tick && state == ST_IDLE;
    assign sel      = tgts[nidx];
    assign sel_fire = state == ST_EMIT && fired[nidx];
    assign lb_we    = sel_fire && sel.ofs == '0;
    assign ext_pkt  = sel_fire && sel.ofs != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            aidx  <= '0;
            nidx  <= '0;
            act_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (tick_acc) begin
                    act_q <= due_row;
                    aidx  <= '0;
                    state <= ST_INTEG;
                end
                ST_INTEG: begin
                    aidx <= AIW'(aidx + 1'b1);
                    if (aidx == AIW'(N_AXON-1)) state <= ST_LEAK;
                end
                ST_LEAK: begin
                    nidx  <= '0;
                    state <= ST_EMIT;
                end
                ST_EMIT: begin
                    nidx <= NIW'(nidx + 1'b1);
                    if (nidx == NIW'(N_NEUR-1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_core  <= '0;
            out_axon  <= '0;
            out_delay <= '0;
        end else begin
            out_valid <= ext_pkt;
            if (ext_pkt) begin
                out_core  <= sel.ofs;
                out_axon  <= sel.axon;
                out_delay <= sel.dly;
            end
        end
    end

    nsc_ring #(.N_AXON(N_AXON)) u_ring (
        .clk(clk), .rst(rst), .tick_acc(tick_acc),
        .ext_we(in_valid), .ext_axon(in_axon), .ext_dly(in_delay),
        .lb_we(lb_we), .lb_axon(sel.axon[AIW-1:0]), .lb_dly(sel.dly),
        .cur_row(due_row)
    );

    nsc_xbar #(.N_AXON(N_AXON), .N_NEUR(N_NEUR)) u_xbar (
        .clk(clk), .rst(rst),
        .we_row(cfg_we && cfg_kind == CF_ROW),
        .we_type(cfg_we && cfg_kind == CF_TYPE),
        .addr(cfg_addr[AIW-1:0]),
        .row_data(cfg_data[N_NEUR-1:0]),
        .type_data(cfg_data[W_TYPE-1:0]),
        .rd_idx(aidx), .rd_row(xb_row), .rd_type(xb_type)
    );

    for (genvar n = 0; n < N_NEUR; n++) begin : g_neur
        logic hit;
        assign hit = cfg_we && cfg_addr == CAW'(n);
        nsc_neuron u_neur (
            .clk(clk), .rst(rst),
            .we_wt(hit && cfg_kind == CF_WT),
            .we_thr(hit && cfg_kind == CF_THR),
            .we_tgt(hit && cfg_kind == CF_TGT),
            .cfg_data(cfg_data),
            .integ_en(state == ST_INTEG && act_q[aidx] && xb_row[n]),
            .atype(xb_type),
            .leak_en(state == ST_LEAK),
            .fired(fired[n]),
            .tgt(tgts[n])
        );
    end

    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !out_valid);

    p_pkt_from_scan_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(state) == ST_EMIT);

endmodule

// File: tb/nsc_core_test.sv
module nsc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_SPAN  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_axon = '0;
    logic [3:0]  in_delay = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_kind = '0;
    logic [3:0]  cfg_addr = '0;
    logic [35:0] cfg_data = '0;
    logic        out_valid;
    logic [3:0]  out_core;
    logic [7:0]  out_axon;
    logic [3:0]  out_delay;

    nsc_core uut (
        .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_axon(in_axon),
        .in_delay(in_delay), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .out_valid(out_valid), .out_core(out_core),
        .out_axon(out_axon), .out_delay(out_delay)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    // bench model of the requirements
    logic [15:0] m_row [16];
    int m_type [16];
    int m_w [16][4];
    int m_thr [16], m_leak [16], m_pot [16];
    int m_ofs [16], m_tax [16], m_tdl [16];
    logic [15:0] m_due [64];
    int tick_no = 0;
    int exp_n;
    int exp_core [16], exp_ax [16], exp_dl [16];
    int cap_n = 0;
    int cap_core [64], cap_ax [64], cap_dl [64];

    always @(negedge clk) begin
        if (!rst && out_valid && cap_n < 64) begin
            cap_core[cap_n] = out_core;
            cap_ax[cap_n]   = out_axon;
            cap_dl[cap_n]   = out_delay;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic cfg(input int kind, input int addr, input logic [35:0] d);
        cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_addr = 4'(addr); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_row(input int a, input logic [15:0] r);
        m_row[a] = r; cfg(0, a, {20'd0, r});
    endtask
    task automatic set_type(input int a, input int t);
        m_type[a] = t; cfg(1, a, 36'(t));
    endtask
    task automatic set_wt(input int n, input int w0, input int w1, input int w2, input int w3);
        m_w[n][0] = w0; m_w[n][1] = w1; m_w[n][2] = w2; m_w[n][3] = w3;
        cfg(2, n, {9'(w3), 9'(w2), 9'(w1), 9'(w0)});
    endtask
    task automatic set_thr(input int n, input int th, input int lk);
        m_thr[n] = th; m_leak[n] = lk;
        cfg(3, n, {15'd0, 9'(lk), 12'(th)});
    endtask
    task automatic set_tgt(input int n, input int ofs, input int ax, input int dl);
        m_ofs[n] = ofs; m_tax[n] = ax; m_tdl[n] = dl;
        cfg(4, n, {20'd0, 4'(dl), 8'(ax), 4'(ofs)});
    endtask

    task automatic send_event(input int a, input int d);
        in_valid = 1'b1; in_axon = 4'(a); in_delay = 4'(d);
        @(negedge clk);
        in_valid = 1'b0;
        m_due[(tick_no + d) % 64] |= 16'(1 << a);
    endtask

    task automatic model_tick();
        logic [15:0] act;
        act = m_due[tick_no % 64];
        m_due[tick_no % 64] = '0;
        tick_no++;
        for (int a = 0; a < 16; a++)
            if (act[a])
                for (int n = 0; n < 16; n++)
                    if (m_row[a][n]) m_pot[n] = sat(m_pot[n] + m_w[n][m_type[a]]);
        exp_n = 0;
        for (int n = 0; n < 16; n++) begin
            int p;
            p = sat(m_pot[n] + m_leak[n]);
            if (p >= m_thr[n]) begin
                m_pot[n] = 0;
                if (m_ofs[n] != 0) begin
                    exp_core[exp_n] = m_ofs[n]; exp_ax[exp_n] = m_tax[n]; exp_dl[exp_n] = m_tdl[n];
                    exp_n++;
                end else begin
                    m_due[(tick_no + m_tdl[n]) % 64] |= 16'(1 << (m_tax[n] % 16));
                end
            end else begin
                m_pot[n] = p;
            end
        end
    endtask

    // one tick; optional event driven so the core samples it at edge inj_cyc after the tick edge
    task automatic run_tick(input bit inj, input int inj_cyc, input int iax, input int idl, input string req);
        cap_n = 0;
        model_tick();
        if (inj) m_due[(tick_no + idl) % 64] |= 16'(1 << iax);
        for (int c = 0; c < TICK_SPAN; c++) begin
            tick = (c == 0);
            in_valid = inj && (c == inj_cyc);
            in_axon = 4'(iax); in_delay = 4'(idl);
            @(negedge clk);
        end
        tick = 1'b0; in_valid = 1'b0;
        chk(cap_n == exp_n, req, "packet count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_core[i] == exp_core[i], "R7", "packet core", cap_core[i], exp_core[i]);
            chk(cap_ax[i] == exp_ax[i], "R7", "packet axon/order", cap_ax[i], exp_ax[i]);
            chk(cap_dl[i] == exp_dl[i], "R7", "packet delay", cap_dl[i], exp_dl[i]);
        end
    endtask

    task automatic plain_tick(input string req);
        run_tick(1'b0, 0, 0, 0, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_row[i] = '0; m_type[i] = 0; m_thr[i] = 2047; m_leak[i] = 0; m_pot[i] = 0;
            m_ofs[i] = 0; m_tax[i] = 0; m_tdl[i] = 0;
            for (int t = 0; t < 4; t++) m_w[i][t] = 0;
        end
        for (int i = 0; i < 64; i++) m_due[i] = '0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset and with no configuration
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        send_event(3, 0);
        plain_tick("R1");
        plain_tick("R1");

        for (int n = 0; n < 16; n++) set_tgt(n, (n % 3) + 1, 8'h80 + n, n);

        // R2: crosspoint sweep, one axon per tick
        for (int n = 0; n < 16; n++) begin
            set_wt(n, 1, 0, 0, 0);
            set_thr(n, 1, 0);
        end
        for (int a = 0; a < 16; a++) begin
            logic [31:0] dbl;
            dbl = {16'hA5C3, 16'hA5C3} >> a;
            set_row(a, dbl[15:0] ^ 16'(1 << a));
        end
        for (int a = 0; a < 16; a++) begin
            send_event(a, 0);
            plain_tick("R2");
        end

        // R10: three axons in one tick summed before the threshold
        for (int n = 0; n < 16; n++) set_thr(n, 2, 0);
        send_event(0, 0); send_event(1, 0); send_event(2, 0);
        plain_tick("R10");
        send_event(5, 0); send_event(9, 0); send_event(14, 0);
        plain_tick("R10");

        // R3: type selection
        for (int a = 0; a < 4; a++) begin
            set_type(a, a);
            set_row(a, 16'hFFFF);
        end
        for (int n = 0; n < 16; n++) begin
            set_wt(n, (n % 4 == 0) ? 5 : 1, (n % 4 == 1) ? 5 : 1, (n % 4 == 2) ? 5 : 1, (n % 4 == 3) ? -7 : 2);
            set_thr(n, 5, 0);
        end
        for (int t = 0; t < 4; t++) begin
            send_event(t, 0);
            plain_tick("R3");
        end

        // R5: leak after integration, equality fires
        for (int a = 0; a < 16; a++) set_type(a, 0);
        for (int n = 0; n < 16; n++) begin
            set_wt(n, 10, 0, 0, 0);
            set_thr(n, 5 + n, -3);
        end
        set_row(0, 16'hFFFF);
        send_event(0, 0); plain_tick("R5");
        plain_tick("R5");
        send_event(0, 0); plain_tick("R5");
        plain_tick("R5");
        for (int n = 0; n < 16; n++) set_thr(n, 5 + n, 2);
        for (int k = 0; k < 4; k++) plain_tick("R5");

        // R4: delays
        for (int n = 0; n < 16; n++) set_thr(n, 8, 0);
        set_row(1, 16'h00F0);
        set_row(2, 16'h0F00);
        send_event(1, 5);
        send_event(2, 2);
        for (int k = 0; k < 7; k++) plain_tick("R4");

        // R6: saturation at both ends
        for (int a = 0; a < 16; a++) set_row(a, 16'hFFFF);
        for (int n = 0; n < 16; n++) begin
            set_wt(n, 255, 0, 0, 0);
            set_thr(n, 2047, 0);
        end
        for (int a = 0; a < 16; a++) send_event(a, 0);
        plain_tick("R6");
        for (int n = 0; n < 16; n++) begin
            set_wt(n, -256, 0, 0, 0);
            set_thr(n, 200, 255);
        end
        for (int a = 0; a < 16; a++) send_event(a, 0);
        for (int k = 0; k < 10; k++) plain_tick("R6");

        // R8: loopback through the core's own schedule
        for (int a = 0; a < 16; a++) set_row(a, 16'h0000);
        for (int n = 0; n < 16; n++) begin
            set_wt(n, 10, 0, 0, 0);
            set_thr(n, 2047, 0);
        end
        plain_tick("R8");
        set_row(0, 16'h0004);
        set_row(5, 16'h0200);
        set_row(6, 16'h0400);
        set_thr(2, 10, 0);
        set_thr(9, 10, 0);
        set_thr(10, 10, 0);
        set_tgt(2, 0, 8'h35, 3);
        send_event(0, 0);
        for (int k = 0; k < 6; k++) plain_tick("R8");

        // R9: external event in the cycle neuron 2 writes its loopback, same slot
        send_event(0, 0);
        run_tick(1'b1, 20, 6, 3, "R9");
        for (int k = 0; k < 5; k++) plain_tick("R9");
        // R9: delay-15 event together with the tick
        run_tick(1'b1, 0, 6, 15, "R9");
        for (int k = 0; k < 17; k++) plain_tick("R9");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule